// File: doc/BRIEF.md
# CAN Standard-ID Dedicated Buffer Filter

This block decides what happens to each received CAN or CAN FD frame that carries an 11-bit standard identifier. It compares the identifier against a small bank of programmable filter elements. When an element matches and asks for normal dedicated storage, the block issues a store request that names a dedicated receive slot. That slot is chosen by the element itself, not by a FIFO. Each stored frame sets a new-data flag for its slot and raises a store interrupt status bit.

A frame descriptor (identifier, remote flag, extended flag, valid strobe) enters on one port. A register-write port programs the filter elements and the global settings, and clears the flag words and the interrupt status. Every frame gets its outcome exactly one clock after its valid strobe. The outcome is a store request, a drop pulse, or neither. Neither means the frame was accepted for some other path or was matched without storage. Frames with extended identifiers are never stored here. Only the global remote-frame and non-matching policies act on them.

Register map (word address on `wr_addr`): 0 holds the global settings, 1 holds the interrupt status, 2 holds flag word 1 (slots 0..31), 3 holds flag word 2 (slots 32..63), and 8+i holds filter element i.

Top module: `canf_sid_filter`

## Requirements
- R1: After reset, `st_vld`, `drop`, `irq`, `nd_lo` and `nd_hi` are all 0. The slot count is 0, every element is inactive, and every global policy bit is clear.
- R2: An element takes part only when its code field (element word bits [31:29]) equals 7, which means store-to-buffer. It then matches a standard frame exactly when the frame ID equals the element's ID field 1 (bits [26:16]). The filter-type field (bits [28:27]) has no effect, and elements with any other code never match.
- R3: Elements are scanned from index 0 upward, and the lowest-index matching element alone decides the outcome. A store request reports that element's index on `st_filt`.
- R4: ID field 2 sits in element word bits [10:0]. Its bits [5:0] give the destination slot and its bits [10:9] give the storage kind. Only kind 00 stores. A match with any other kind gives neither a store nor a drop.
- R5: Global word bits [14:8] hold the number of dedicated slots, with values above 64 read as 64. A kind-00 match whose slot is not below that count is dropped and not stored.
- R6: A store to slot n sets bit n of `nd_lo` when n < 32, or bit n-32 of `nd_hi` otherwise, on the same edge that raises `st_vld`. A frame aimed at a slot whose flag is already set is still stored, and the flag stays set.
- R7: Writing address 2 or 3 clears each flag bit where the data has a 1 and leaves bits with a 0 unchanged. If a store sets a bit in the same cycle that a write clears it, the bit ends set.
- R8: A store sets the interrupt status. Writing 1 to bit 0 of address 1 clears the status, and writing 0 leaves it set. `irq` equals the status ANDed with the interrupt enable (global bit 4), so a status set while the enable is off appears on `irq` once the enable is turned on.
- R9: A remote standard frame is dropped when global bit 0 is set, even if an element matches. A remote extended frame is dropped when global bit 1 is set. Each bit affects only its own frame format.
- R10: A standard frame that matches no element is dropped when global bit 2 is set, and otherwise gives neither a store nor a drop. Global bit 3 does the same for extended frames.
- R11: An extended frame never produces a store, whatever its low 11 identifier bits are.
- R12: The outcome of a frame presented with `rx_vld` high appears for exactly one cycle, on the cycle after. Back-to-back frames get back-to-back outcomes, and no outcome appears without a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_vld | input | 1 | Frame descriptor valid strobe |
| rx_id | input | 29 | Frame identifier; a standard ID uses bits [10:0] |
| rx_rtr | input | 1 | Remote frame flag |
| rx_xtd | input | 1 | Extended identifier flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Register write data |
| st_vld | output | 1 | Store request strobe |
| st_slot | output | 6 | Destination dedicated slot |
| st_filt | output | 3 | Index of the matching element |
| drop | output | 1 | Frame rejected strobe |
| nd_lo | output | 32 | New-data flags, slots 0..31 |
| nd_hi | output | 32 | New-data flags, slots 32..63 |
| irq | output | 1 | Store interrupt |

## Verification
The hardest case to reach from the ports is a store that lands on a slot in the same cycle as a write-one-to-clear of that slot's flag. In that case the set has to win. The bench raises the register write and the frame strobe on the same clock edge, so the race is exercised directly rather than inferred. The slot-count boundary is also covered, at one below and exactly at the configured count, with slots landing at 31, 32 and 63 across both flag words. The interrupt enable is toggled while the status is pending.

// File: rtl/canf_pkg.sv
package canf_pkg;

    localparam int ID_W      = 11;
    localparam int XID_W     = 29;
    localparam int SLOT_W    = 6;
    localparam int SLOTS_MAX = 64;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 7;
    localparam int FIDX_W    = 3;
    localparam int FILT_MAX  = 8;

    localparam logic [2:0] CODE_STBUF  = 3'd7;
    localparam logic [1:0] KIND_NORMAL = 2'b00;

    localparam int ADR_GCFG  = 0;
    localparam int ADR_ISTAT = 1;
    localparam int ADR_NDLO  = 2;
    localparam int ADR_NDHI  = 3;
    localparam int ADR_ELEM0 = 8;

    // one filter element as held in the register bank
    typedef struct packed {
        logic [2:0]        code;
        logic [ID_W-1:0]   id1;
        logic [1:0]        kind;
        logic [SLOT_W-1:0] slot;
    } felem_t;

    // global settings
    typedef struct packed {
        logic             rtr_rej_std;
        logic             rtr_rej_ext;
        logic             nm_rej_std;
        logic             nm_rej_ext;
        logic             irq_en;
        logic [CNT_W-1:0] nslots;
    } gcfg_t;

    function automatic felem_t elem_from_word(logic [WORD_W-1:0] w);
        felem_t e;
        e.code = w[31:29];
        e.id1  = w[26:16];
        e.kind = w[10:9];
        e.slot = w[5:0];
        return e;
    endfunction

    function automatic gcfg_t gcfg_from_word(logic [WORD_W-1:0] w);
        gcfg_t g;
        g.rtr_rej_std = w[0];
        g.rtr_rej_ext = w[1];
        g.nm_rej_std  = w[2];
        g.nm_rej_ext  = w[3];
        g.irq_en      = w[4];
        g.nslots      = (w[14:8] > CNT_W'(SLOTS_MAX)) ? CNT_W'(SLOTS_MAX) : w[14:8];
        return g;
    endfunction

endpackage

// File: rtl/canf_cfg_regs.sv
module canf_cfg_regs
    import canf_pkg::*;
#(
    parameter int NUM_FILT = 5,
    parameter int ADDR_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [WORD_W-1:0]         wr_data,
    output gcfg_t                     gcfg_o,
    output felem_t [NUM_FILT-1:0]     elem_o
);

    typedef struct packed {
        gcfg_t                 gcfg;
        felem_t [NUM_FILT-1:0] elem;
    } cfg_st_t;

    cfg_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_GCFG)) begin
                s_d.gcfg = gcfg_from_word(wr_data);
            end
            for (int i = 0; i < NUM_FILT; i++) begin
                if (wr_addr == ADDR_W'(ADR_ELEM0 + i)) begin
                    s_d.elem[i] = elem_from_word(wr_data);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gcfg_o = s_q.gcfg;
    assign elem_o = s_q.elem;

    // R5: the slot count can never exceed the slot capacity
    a_r5_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.gcfg.nslots <= CNT_W'(SLOTS_MAX));

endmodule

// File: rtl/canf_elem_match.sv
module canf_elem_match
    import canf_pkg::*;
(
    input  logic [2:0]      code_i,
    input  logic [ID_W-1:0] id1_i,
    input  logic [ID_W-1:0] id_i,
    output logic            hit_o
);

    // store-to-buffer elements compare the whole ID; the type field is not consulted
    assign hit_o = (code_i == CODE_STBUF) && (id1_i == id_i);

endmodule

// File: rtl/canf_scan.sv
module canf_scan
    import canf_pkg::*;
#(
    parameter int NUM_FILT = 5
) (
    input  felem_t [NUM_FILT-1:0] elem_i,
    input  logic [ID_W-1:0]       id_i,
    output logic                  hit_o,
    output logic [FIDX_W-1:0]     idx_o,
    output logic [1:0]            kind_o,
    output logic [SLOT_W-1:0]     slot_o
);

    logic [NUM_FILT-1:0] hit_vec;

    generate
        for (genvar g = 0; g < NUM_FILT; g++) begin : g_elem
            canf_elem_match u_match (
                .code_i (elem_i[g].code),
                .id1_i  (elem_i[g].id1),
                .id_i   (id_i),
                .hit_o  (hit_vec[g])
            );
        end
    endgenerate

    // walk from the top down so that the lowest matching index is left standing
    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        kind_o = '0;
        slot_o = '0;
        for (int i = NUM_FILT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_o  = 1'b1;
                idx_o  = FIDX_W'(i);
                kind_o = elem_i[i].kind;
                slot_o = elem_i[i].slot;
            end
        end
    end

endmodule

// File: rtl/canf_ndat.sv
module canf_ndat
    import canf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic [SLOT_W-1:0] set_slot_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              irq_en_i,
    output logic [WORD_W-1:0] nd_lo_o,
    output logic [WORD_W-1:0] nd_hi_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [SLOTS_MAX-1:0] nd;
        logic                 stat;
    } nd_st_t;

    nd_st_t s_d, s_q;

    logic [SLOTS_MAX-1:0] clr_mask;
    logic [SLOTS_MAX-1:0] set_mask;
    logic                 stat_clr;

    always_comb begin
        clr_mask = '0;
        stat_clr = 1'b0;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_NDLO)) clr_mask[WORD_W-1:0]         = wr_data;
            if (wr_addr == ADDR_W'(ADR_NDHI)) clr_mask[SLOTS_MAX-1:WORD_W] = wr_data;
            if (wr_addr == ADDR_W'(ADR_ISTAT)) stat_clr = wr_data[0];
        end
        set_mask = '0;
        if (set_i) set_mask[set_slot_i] = 1'b1;

        s_d      = s_q;
        // a set in the same cycle as a clear leaves the bit set
        s_d.nd   = (s_q.nd & ~clr_mask) | set_mask;
        s_d.stat = (s_q.stat & ~stat_clr) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign nd_lo_o = s_q.nd[WORD_W-1:0];
    assign nd_hi_o = s_q.nd[SLOTS_MAX-1:WORD_W];
    assign irq_o   = s_q.stat & irq_en_i;

    // R6: a store leaves its slot flag set on the next cycle
    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> s_q.nd[$past(set_slot_i)]);

    // R7: a clear of word 1 with no concurrent store leaves the written bits low
    a_r7_clear_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(ADR_NDLO) && !set_i)
            |=> ((s_q.nd[WORD_W-1:0] & $past(wr_data)) == '0));

    // R8: a store always leaves the interrupt status pending
    a_r8_stat_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> s_q.stat);

endmodule

// File: rtl/canf_sid_filter.sv
module canf_sid_filter
    import canf_pkg::*;
#(
    parameter int NUM_FILT = 5,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_vld,
    input  logic [28:0]       rx_id,
    input  logic              rx_rtr,
    input  logic              rx_xtd,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              st_vld,
    output logic [5:0]        st_slot,
    output logic [2:0]        st_filt,
    output logic              drop,
    output logic [31:0]       nd_lo,
    output logic [31:0]       nd_hi,
    output logic              irq
);

    typedef struct packed {
        logic              st;
        logic [SLOT_W-1:0] slot;
        logic [FIDX_W-1:0] filt;
        logic              drop;
    } out_st_t;

    gcfg_t                 gcfg;
    felem_t [NUM_FILT-1:0] elem;
    logic                  scan_hit;
    logic [FIDX_W-1:0]     scan_idx;
    logic [1:0]            scan_kind;
    logic [SLOT_W-1:0]     scan_slot;
    out_st_t               o_d, o_q;

    canf_cfg_regs #(
        .NUM_FILT (NUM_FILT),
        .ADDR_W   (ADDR_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .gcfg_o  (gcfg),
        .elem_o  (elem)
    );

    canf_scan #(
        .NUM_FILT (NUM_FILT)
    ) u_scan (
        .elem_i (elem),
        .id_i   (rx_id[ID_W-1:0]),
        .hit_o  (scan_hit),
        .idx_o  (scan_idx),
        .kind_o (scan_kind),
        .slot_o (scan_slot)
    );

    // outcome of the presented frame
    always_comb begin
        o_d = '0;
        if (rx_vld) begin
            if (rx_xtd) begin
                o_d.drop = (rx_rtr && gcfg.rtr_rej_ext) || gcfg.nm_rej_ext;
            end else if (rx_rtr && gcfg.rtr_rej_std) begin
                o_d.drop = 1'b1;
            end else if (scan_hit) begin
                if (scan_kind == KIND_NORMAL) begin
                    if ({1'b0, scan_slot} < gcfg.nslots) begin
                        o_d.st   = 1'b1;
                        o_d.slot = scan_slot;
                        o_d.filt = scan_idx;
                    end else begin
                        o_d.drop = 1'b1;
                    end
                end
            end else begin
                o_d.drop = gcfg.nm_rej_std;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    canf_ndat #(
        .ADDR_W (ADDR_W)
    ) u_ndat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (o_d.st),
        .set_slot_i (o_d.slot),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .irq_en_i   (gcfg.irq_en),
        .nd_lo_o    (nd_lo),
        .nd_hi_o    (nd_hi),
        .irq_o      (irq)
    );

    assign st_vld  = o_q.st;
    assign st_slot = o_q.slot;
    assign st_filt = o_q.filt;
    assign drop    = o_q.drop;

    // R12, R11: a store request only follows a standard frame strobe
    a_r12_store_follows_frame: assert property (@(posedge clk) disable iff (!rst_n)
        st_vld |-> ($past(rx_vld) && !$past(rx_xtd)));

    // R5: stored slots lie below the slot count in force when the frame arrived
    a_r5_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_vld |-> ({1'b0, st_slot} < $past(gcfg.nslots)));

    // R4: one frame yields at most one kind of outcome
    a_r4_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_vld && drop));

    // R3: the element chosen by the scan really matches the frame
    a_r3_winner_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && scan_hit) |->
            (elem[scan_idx].code == CODE_STBUF && elem[scan_idx].id1 == rx_id[ID_W-1:0]));

endmodule

// File: tb/test_canf_sid_filter.sv
`timescale 1ns/1ps
module test_canf_sid_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_vld = 1'b0;
    logic [28:0] rx_id = '0;
    logic        rx_rtr = 1'b0;
    logic        rx_xtd = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        st_vld, drop, irq;
    logic [5:0]  st_slot;
    logic [2:0]  st_filt;
    logic [31:0] nd_lo, nd_hi;

    always #4 clk = ~clk;

    canf_sid_filter i_canf_sid_filter (
        .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_id(rx_id), .rx_rtr(rx_rtr),
        .rx_xtd(rx_xtd), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .st_vld(st_vld), .st_slot(st_slot), .st_filt(st_filt), .drop(drop),
        .nd_lo(nd_lo), .nd_hi(nd_hi), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model state
    logic        m_rrs = 0, m_rrx = 0, m_rjs = 0, m_rjx = 0, m_ien = 0;
    int          m_ns = 0;
    logic [2:0]  m_code [8];
    logic [10:0] m_id1 [8];
    logic [1:0]  m_kind [8];
    logic [5:0]  m_slot [8];
    logic [63:0] m_nd = '0;
    logic        m_stat = 0;

    int    q_kind [$];
    int    q_slot [$];
    int    q_filt [$];
    string q_req [$];

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_code[i] = '0; m_id1[i] = '0; m_kind[i] = '0; m_slot[i] = '0;
        end
    end

    function automatic logic [31:0] fw(logic [2:0] code, logic [1:0] ftype, logic [10:0] id1,
                                       logic [1:0] kind, logic [5:0] slot);
        return {code, ftype, id1, 5'b0, kind, 3'b0, slot};
    endfunction

    function automatic logic [31:0] cw(logic rrs, logic rrx, logic rjs, logic rjx, logic ien,
                                       logic [6:0] ns);
        return {17'b0, ns, 3'b0, ien, rjx, rjs, rrx, rrs};
    endfunction

    function automatic void model_wr(logic [3:0] a, logic [31:0] d);
        if (a == 4'd0) begin
            m_rrs = d[0]; m_rrx = d[1]; m_rjs = d[2]; m_rjx = d[3]; m_ien = d[4];
            m_ns = (int'(d[14:8]) > 64) ? 64 : int'(d[14:8]);
        end else if (a == 4'd1) begin
            if (d[0]) m_stat = 1'b0;
        end else if (a == 4'd2) begin
            m_nd[31:0] = m_nd[31:0] & ~d;
        end else if (a == 4'd3) begin
            m_nd[63:32] = m_nd[63:32] & ~d;
        end else if (a >= 4'd8 && a < 4'd13) begin
            m_code[a-8] = d[31:29]; m_id1[a-8] = d[26:16];
            m_kind[a-8] = d[10:9];  m_slot[a-8] = d[5:0];
        end
    endfunction

    // kind: 0 neither, 1 store, 2 drop
    function automatic void predict(logic [28:0] id, logic rtr, logic xtd, string req);
        int   kind = 0;
        int   slot = 0;
        int   filt = 0;
        logic found = 0;
        if (xtd) begin
            if ((rtr && m_rrx) || m_rjx) kind = 2;
        end else if (rtr && m_rrs) begin
            kind = 2;
        end else begin
            for (int i = 0; i < 5; i++) begin
                if (!found && m_code[i] == 3'd7 && m_id1[i] == id[10:0]) begin
                    found = 1;
                    filt  = i;
                    if (m_kind[i] == 2'b00) begin
                        slot = int'(m_slot[i]);
                        kind = (slot < m_ns) ? 1 : 2;
                    end
                end
            end
            if (!found && m_rjs) kind = 2;
        end
        if (kind == 1) begin
            m_nd[slot] = 1'b1;
            m_stat     = 1'b1;
        end
        q_kind.push_back(kind);
        q_slot.push_back(slot);
        q_filt.push_back(filt);
        q_req.push_back(req);
    endfunction

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        model_wr(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(logic [28:0] id, logic rtr, logic xtd, string req);
        @(negedge clk);
        rx_vld = 1'b1; rx_id = id; rx_rtr = rtr; rx_xtd = xtd;
        predict(id, rtr, xtd, req);
    endtask

    task automatic idle();
        @(negedge clk);
        rx_vld = 1'b0; rx_rtr = 1'b0; rx_xtd = 1'b0;
    endtask

    task automatic frame(logic [28:0] id, logic rtr, logic xtd, string req);
        send(id, rtr, xtd, req);
        idle();
    endtask

    task automatic chk_state(string req);
        check({req, " nd_lo"}, 64'(nd_lo), 64'(m_nd[31:0]));
        check({req, " nd_hi"}, 64'(nd_hi), 64'(m_nd[63:32]));
        check({req, " irq"}, 64'(irq), 64'(m_stat & m_ien));
    endtask

    // monitor: compares each frame outcome against the scoreboard
    logic seen = 1'b0;
    always @(posedge clk) seen <= rx_vld;

    always @(negedge clk) begin
        if (rst_n) begin
            if (seen) begin
                if (q_kind.size() == 0) begin
                    check("R12 outcome without expectation", 64'(1), 64'(0));
                end else begin
                    int    ek, es, ef, ak;
                    string er;
                    ek = q_kind.pop_front(); es = q_slot.pop_front();
                    ef = q_filt.pop_front(); er = q_req.pop_front();
                    ak = st_vld ? 1 : (drop ? 2 : 0);
                    if (st_vld && drop) ak = 3;
                    check({er, " outcome"}, 64'(ak), 64'(ek));
                    if (ek == 1) begin
                        check({er, " slot"}, 64'(st_slot), 64'(es));
                        check({er, " filter index"}, 64'(st_filt), 64'(ef));
                    end
                end
            end else if (st_vld || drop) begin
                check("R12 spurious outcome", 64'({st_vld, drop}), 64'(0));
            end
        end
    end

    logic done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 st_vld", 64'(st_vld), 0);
        check("R1 drop", 64'(drop), 0);
        check("R1 nd_lo", 64'(nd_lo), 0);
        check("R1 nd_hi", 64'(nd_hi), 0);
        check("R1 irq", 64'(irq), 0);
        // R1: slot count 0 and inactive elements after reset
        frame(29'h055, 0, 0, "R1 idle config");

        wr(4'd0, cw(0, 0, 0, 0, 1, 7'd10));
        // R2: type field set to 2, still exact match
        wr(4'd8, fw(3'd7, 2'd2, 11'h055, 2'b00, 6'd1));
        frame(29'h055, 0, 0, "R2 exact match");
        chk_state("R6 slot 1");
        frame(29'h054, 0, 0, "R2 near id");
        frame(29'h056, 0, 0, "R10 accept nonmatch std");
        wr(4'd0, cw(0, 0, 1, 0, 1, 7'd10));
        frame(29'h056, 0, 0, "R10 reject nonmatch std");

        // R3: two elements with the same id, lower index wins
        wr(4'd9,  fw(3'd7, 2'd0, 11'h115, 2'b00, 6'd3));
        wr(4'd10, fw(3'd7, 2'd1, 11'h115, 2'b00, 6'd4));
        frame(29'h115, 0, 0, "R3 first match");
        // R2: non store-to-buffer code never matches
        wr(4'd11, fw(3'd5, 2'd0, 11'h200, 2'b00, 6'd5));
        frame(29'h200, 0, 0, "R2 other code");
        // R4: storage kinds other than 00
        wr(4'd12, fw(3'd7, 2'd0, 11'h300, 2'b01, 6'd2));
        frame(29'h300, 0, 0, "R4 kind 01");
        wr(4'd12, fw(3'd7, 2'd3, 11'h300, 2'b11, 6'd2));
        frame(29'h300, 0, 0, "R4 kind 11");
        chk_state("R4 no store");

        // R12 back-to-back frames
        send(29'h055, 0, 0, "R12 b2b a");
        send(29'h115, 0, 0, "R12 b2b b");
        send(29'h056, 0, 0, "R12 b2b c");
        idle();
        chk_state("R12 b2b");

        // R5 slot count boundary
        wr(4'd0, cw(0, 0, 1, 0, 1, 7'd40));
        wr(4'd8, fw(3'd7, 2'd0, 11'h055, 2'b00, 6'd40));
        frame(29'h055, 0, 0, "R5 at count");
        wr(4'd8, fw(3'd7, 2'd0, 11'h055, 2'b00, 6'd39));
        frame(29'h055, 0, 0, "R5 below count");
        chk_state("R6 slot 39");
        wr(4'd0, cw(0, 0, 1, 0, 1, 7'd100));
        wr(4'd8, fw(3'd7, 2'd0, 11'h055, 2'b00, 6'd63));
        frame(29'h055, 0, 0, "R5 clamp slot 63");
        wr(4'd8, fw(3'd7, 2'd0, 11'h055, 2'b00, 6'd32));
        frame(29'h055, 0, 0, "R6 slot 32");
        wr(4'd8, fw(3'd7, 2'd0, 11'h055, 2'b00, 6'd31));
        frame(29'h055, 0, 0, "R6 slot 31");
        chk_state("R6 both words");
        frame(29'h055, 0, 0, "R6 restore set slot");
        chk_state("R6 flag stays");

        // R7 write-one-to-clear
        wr(4'd2, 32'h0);
        chk_state("R7 zero write");
        wr(4'd2, 32'h8000_0002);
        chk_state("R7 clear lo");
        wr(4'd3, 32'h8000_0081);
        chk_state("R7 clear hi");
        // R7 store and clear of slot 31 in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd2; wr_data = 32'h8000_0000;
        rx_vld = 1'b1; rx_id = 29'h055; rx_rtr = 1'b0; rx_xtd = 1'b0;
        model_wr(4'd2, 32'h8000_0000);
        predict(29'h055, 0, 0, "R7 race store");
        @(negedge clk);
        wr_en = 1'b0; rx_vld = 1'b0;
        chk_state("R7 set wins");

        // R8 interrupt status and enable
        wr(4'd1, 32'h0);
        chk_state("R8 zero write");
        wr(4'd1, 32'h1);
        chk_state("R8 cleared");
        wr(4'd0, cw(0, 0, 1, 0, 0, 7'd64));
        frame(29'h055, 0, 0, "R8 store masked");
        chk_state("R8 masked");
        wr(4'd0, cw(0, 0, 1, 0, 1, 7'd64));
        chk_state("R8 enabled pending");

        // R9 R10 R11 remote and extended frames
        wr(4'd0, cw(0, 0, 0, 0, 1, 7'd64));
        frame(29'h055, 1, 0, "R9 remote std accepted");
        frame(29'h055, 1, 1, "R11 remote ext no policy");
        frame(29'h055, 0, 1, "R11 ext never stored");
        wr(4'd0, cw(1, 0, 0, 0, 1, 7'd64));
        frame(29'h055, 1, 0, "R9 remote std rejected");
        frame(29'h055, 1, 1, "R9 ext unaffected by std bit");
        frame(29'h056, 0, 0, "R10 std accept stays");
        wr(4'd0, cw(0, 1, 0, 0, 1, 7'd64));
        frame(29'h055, 1, 1, "R9 remote ext rejected");
        frame(29'h055, 1, 0, "R9 std unaffected by ext bit");
        wr(4'd0, cw(0, 0, 0, 1, 1, 7'd64));
        frame(29'h1234_5055, 0, 1, "R10 reject nonmatch ext");
        frame(29'h056, 0, 0, "R10 std unaffected by ext policy");
        chk_state("R11 final flags");

        repeat (3) @(negedge clk);
        check("R12 scoreboard drained", 64'(q_kind.size()), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R12 watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule